// File: doc/BRIEF.md
# Clock Channel Select with Write Lock

This block hands one gated clock to each consumer on a chip. Every channel holds a small configuration: which of the free-running generator clocks feeds it, whether the clock passes through, and a lock flag that freezes the configuration until the next block reset. Software reaches all channels through a single 16-bit indexed register. A write to the low byte names a channel. A write to the high byte changes that channel's fields. The registered read port always shows the currently named channel.

Each channel's gate sits in the domain of its generator. The enable passes through a synchronizer clocked by that generator. The gate then opens or closes on the generator's falling edge, so every output pulse has full width. The gate state is synchronized back into the register clock domain. The enable bit that software reads is the OR of the stored enable and that returned gate state. After software clears the enable, it can therefore poll the bit until it reads 0, and the clock is then known to be stopped.

Top module: `clk_chan_select`

## Requirements
- R1: After reset, every channel is disabled, unlocked and selects generator 0, the named channel is 0, `rd_data` reads 0x0000 and every `chan_clk` bit stays low.
- R2: A write with `wr_be[0]` set names a channel. The channel number is taken from the low log2(NUM_CH) bits of `wr_data[7:0]`, and higher bits of that byte are dropped. The named channel is kept until the next such write.
- R3: A write with `wr_be[1]` set loads three fields into the target channel: the generator select from `wr_data[8 +: log2(NUM_GEN)]`, the enable from `wr_data[14]` and the lock from `wr_data[15]`. Bits 13:10 are ignored. When both byte enables are set in one write, the target is the channel named by that same write.
- R4: `rd_data` is registered one cycle behind the state. It shows the named channel number in bits [7:0], its generator select in bits [8 +: log2(NUM_GEN)], its enable readback in bit 14 and its lock in bit 15. All other bits read 0.
- R5: While a channel's gate is open, its `chan_clk` bit follows the selected `gen_clk` bit. While the gate is closed, the output is held low.
- R6: After the enable of an open channel is cleared, bit 14 of the readback stays 1 until the gate has closed. It reads 0 only once the channel clock has stopped.
- R7: Once the lock is set, writes that target that channel change none of its fields. The write that sets the lock applies its other fields as well. Only reset clears the lock. Other channels remain writable.
- R8: The gate changes state only while the generator clock is low, so every high pulse on `chan_clk` lasts a full generator half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-interface clock |
| rst | input | 1 | Synchronous active-high reset, also sampled in each generator domain |
| gen_clk | input | NUM_GEN | Free-running generator clocks |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte enables: bit 0 names the channel, bit 1 writes its fields |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered view of the named channel |
| chan_clk | output | NUM_CH | Gated per-channel clock outputs |

## Verification
Two functions can land in the same write cycle: naming a channel and updating its fields. A write with both byte enables set must apply the fields to the channel named in that same write, not to the one named before it. The bench interleaves these combined writes with high-byte-only writes to channels named earlier, and compares each readback against the table's expected word. A second same-cycle case is setting the lock together with the enable. The enable must take effect even though the lock blocks every later write, and the bench confirms this from the running clock.

// File: rtl/clk_chan_select_pkg.sv
`timescale 1ns/1ps
package clk_chan_select_pkg;
  // Register word layout: byte 0 names the channel, byte 1 carries the fields.
  localparam int REG_W      = 16;
  localparam int CH_FIELD_W = 8;
  localparam int GEN_LSB    = 8;
  localparam int GEN_FIELD_W = 4;
  localparam int EN_BIT     = 14;
  localparam int LOCK_BIT   = 15;
endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ccs_gate.sv
`timescale 1ns/1ps
module ccs_gate #(
  parameter int NUM_GEN     = 4,
  parameter int GEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_GEN-1:0] gen_clk,
  input  logic [GEN_W-1:0]   gen_sel,
  input  logic               enable,
  output logic               gate_seen,
  output logic               clk_out
);
  logic src_clk;
  logic en_src;
  logic gate_q;

  assign src_clk = gen_clk[gen_sel];

  // Enable crosses into the generator domain.
  ccs_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(src_clk), .rst(rst), .d(enable), .q(en_src)
  );

  // Gate moves on the falling edge only, while the source is low.
  always_ff @(negedge src_clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= en_src;
  end

  assign clk_out = src_clk & gate_q;

  // Actual gate state returns to the register domain.
  ccs_sync #(.STAGES(SYNC_STAGES)) u_back_sync (
    .clk(clk), .rst(rst), .d(gate_q), .q(gate_seen)
  );
endmodule

// File: rtl/ccs_regs.sv
`timescale 1ns/1ps
module ccs_regs
  import clk_chan_select_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 4,
  localparam int CH_W   = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1,
  localparam int GEN_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_be,
  input  logic [REG_W-1:0]             wr_data,
  output logic [CH_W-1:0]              sel_o,
  output logic [NUM_CH-1:0][GEN_W-1:0] cfg_gen_o,
  output logic [NUM_CH-1:0]            cfg_en_o,
  output logic [NUM_CH-1:0]            cfg_lock_o
);
  logic [CH_W-1:0]              sel_q;
  logic [NUM_CH-1:0][GEN_W-1:0] gen_q;
  logic [NUM_CH-1:0]            en_q;
  logic [NUM_CH-1:0]            lock_q;
  logic [CH_W-1:0]              tgt;
  logic                         unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  // A combined write acts on the channel it names.
  assign tgt = wr_be[0] ? wr_data[CH_W-1:0] : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      gen_q  <= '0;
      en_q   <= '0;
      lock_q <= '0;
    end else if (wr_en) begin
      if (wr_be[0]) sel_q <= wr_data[CH_W-1:0];
      if (wr_be[1] && !lock_q[tgt]) begin
        gen_q[tgt]  <= wr_data[GEN_LSB +: GEN_W];
        en_q[tgt]   <= wr_data[EN_BIT];
        lock_q[tgt] <= wr_data[LOCK_BIT];
      end
    end
  end

  assign sel_o      = sel_q;
  assign cfg_gen_o  = gen_q;
  assign cfg_en_o   = en_q;
  assign cfg_lock_o = lock_q;

  assert_reset_defaults_R1: assert property (@(posedge clk)
    rst |=> (sel_q == '0 && gen_q == '0 && en_q == '0 && lock_q == '0));

  assert_select_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[0]) |=> (sel_q == $past(wr_data[CH_W-1:0])));

  assert_field_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[1] && !lock_q[tgt]) |=>
      (gen_q[$past(tgt)] == $past(wr_data[GEN_LSB +: GEN_W]) &&
       en_q[$past(tgt)]  == $past(wr_data[EN_BIT]) &&
       lock_q[$past(tgt)] == $past(wr_data[LOCK_BIT])));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lock_chk
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> (lock_q[i] && $stable(gen_q[i]) && $stable(en_q[i])));
  end
endmodule

// File: rtl/clk_chan_select.sv
`timescale 1ns/1ps
module clk_chan_select
  import clk_chan_select_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_GEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_GEN-1:0] gen_clk,
  input  logic               wr_en,
  input  logic [1:0]         wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_CH-1:0]  chan_clk
);
  localparam int CH_W  = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1;
  localparam int GEN_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

  logic [CH_W-1:0]              sel;
  logic [NUM_CH-1:0][GEN_W-1:0] cfg_gen;
  logic [NUM_CH-1:0]            cfg_en;
  logic [NUM_CH-1:0]            cfg_lock;
  logic [NUM_CH-1:0]            gate_seen;
  logic [REG_W-1:0]             view;

  ccs_regs #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .sel_o(sel), .cfg_gen_o(cfg_gen), .cfg_en_o(cfg_en), .cfg_lock_o(cfg_lock)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    ccs_gate #(.NUM_GEN(NUM_GEN), .GEN_W(GEN_W), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst(rst), .gen_clk(gen_clk), .gen_sel(cfg_gen[g]),
      .enable(cfg_en[g]), .gate_seen(gate_seen[g]), .clk_out(chan_clk[g])
    );
  end

  // Enable readback holds 1 while the gate is still open.
  always_comb begin
    view                      = '0;
    view[CH_W-1:0]            = sel;
    view[GEN_LSB +: GEN_W]    = cfg_gen[sel];
    view[EN_BIT]              = cfg_en[sel] | gate_seen[sel];
    view[LOCK_BIT]            = cfg_lock[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= view;
  end

  assert_enable_view_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_en[sel] |=> rd_data[EN_BIT]);
endmodule

// File: tb/test_clk_chan_select.sv
`timescale 1ns/1ps
module test_clk_chan_select;
  localparam int NCH = 8;
  localparam int NGEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic g0 = 1'b0, g1 = 1'b0, g2 = 1'b0, g3 = 1'b0;
  logic [NGEN-1:0] gen_clk;
  logic wr_en = 1'b0;
  logic [1:0] wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [NCH-1:0] chan_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  assign gen_clk = {g3, g2, g1, g0};

  always #10 clk = ~clk;
  initial forever #15 g0 = ~g0;
  initial forever #25 g1 = ~g1;
  initial forever #35 g2 = ~g2;
  initial forever #55 g3 = ~g3;

  clk_chan_select i_clk_chan_select (
    .clk(clk), .rst(rst), .gen_clk(gen_clk), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .chan_clk(chan_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pulse-width monitor for R8.
  int  mon_ch = 0;
  real mon_hp = 15.0;
  bit  mon_on = 1'b0;
  realtime t_rise = 0;
  logic mon_sig;
  assign mon_sig = chan_clk[mon_ch];
  always @(posedge mon_sig) t_rise = $realtime;
  always @(negedge mon_sig) begin
    if (mon_on) begin
      real w;
      w = $realtime - t_rise;
      n_cmp++;
      if (w < mon_hp - 0.05 || w > mon_hp + 0.05) begin
        n_bad++;
        $display("FAIL R8 pulse width actual=%0.2f expected=%0.2f", w, mon_hp);
      end
    end
  end

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk(req, {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic follow(input string req, input int ch, input int g);
    int bad = 0;
    @(negedge clk); #0.3;
    for (int k = 0; k < 60; k++) begin
      #7;
      if (chan_clk[ch] !== gen_clk[g]) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic stay_low(input string req, input int ch);
    int bad = 0;
    @(negedge clk); #0.3;
    for (int k = 0; k < 45; k++) begin
      #7;
      if (chan_clk[ch] !== 1'b0) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic wait_off(input string req);
    int n = 0;
    while (rd_data[14] !== 1'b0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'h0, rd_data[14]}, 32'h0);
  endtask

  // {byte enables, write data, expected readback}: R2, R3, R4
  localparam logic [33:0] VEC [9] = '{
    {2'b01, 16'h0003, 16'h0003},
    {2'b10, 16'h0200, 16'h0203},
    {2'b01, 16'h00FD, 16'h0005},
    {2'b11, 16'h0106, 16'h0106},
    {2'b01, 16'h0003, 16'h0203},
    {2'b10, 16'h0300, 16'h0303},
    {2'b11, 16'h0201, 16'h0201},
    {2'b01, 16'h0006, 16'h0106},
    {2'b11, 16'h3C06, 16'h0006}
  };

  initial begin
    idle(10);
    rst = 1'b0;
    idle(2);
    chk("R1 readback", {16'h0, rd_data}, 32'h0);
    chk("R1 outputs", {24'h0, chan_clk}, 32'h0);
    stay_low("R1 ch0 low", 0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][33:32], VEC[i][31:16]);
      rd_chk("R2/R3/R4 vector", VEC[i][15:0]);
    end

    // R5/R8: enable ch1 on generator 2
    mon_ch = 1; mon_hp = 35.0; mon_on = 1'b1;
    wr(2'b11, 16'h4201);
    rd_chk("R3 enable ch1", 16'h4201);
    idle(20);
    follow("R5 ch1 follows gen2", 1, 2);
    stay_low("R5 ch0 disabled", 0);
    // R6: disable ch1
    wr(2'b11, 16'h0201);
    wait_off("R6 ch1 readback clears");
    stay_low("R6 ch1 stopped", 1);
    mon_on = 1'b0;

    // R6: slow generator shows delayed clearing
    wr(2'b11, 16'h4303);
    idle(20);
    follow("R5 ch3 follows gen3", 3, 3);
    wr(2'b10, 16'h0300);
    @(negedge clk);
    chk("R6 still reads enabled", {31'h0, rd_data[14]}, 32'h1);
    wait_off("R6 ch3 readback clears");
    stay_low("R6 ch3 stopped", 3);

    // R7: lock ch6
    wr(2'b11, 16'h8106);
    rd_chk("R7 lock set", 16'h8106);
    wr(2'b11, 16'h4306);
    rd_chk("R7 locked write ignored", 16'h8106);
    wr(2'b10, 16'h4300);
    rd_chk("R7 locked high byte ignored", 16'h8106);
    idle(20);
    stay_low("R7 locked ch6 stays off", 6);
    wr(2'b11, 16'h4205);
    rd_chk("R7 other channel writable", 16'h4205);
    idle(20);
    follow("R5 ch5 follows gen2", 5, 2);

    // R7: lock and enable in one write
    mon_ch = 4; mon_hp = 15.0; mon_on = 1'b1;
    wr(2'b11, 16'hC004);
    rd_chk("R7 lock with enable", 16'hC004);
    wr(2'b11, 16'h0004);
    rd_chk("R7 disable blocked", 16'hC004);
    idle(20);
    follow("R7 ch4 keeps running", 4, 0);

    // R1/R7: reset clears everything including locks
    @(negedge clk);
    rst = 1'b1;
    idle(12);
    mon_on = 1'b0;
    rst = 1'b0;
    idle(2);
    chk("R1 readback after reset", {16'h0, rd_data}, 32'h0);
    chk("R1 outputs after reset", {24'h0, chan_clk}, 32'h0);
    stay_low("R1 ch4 off after reset", 4);
    wr(2'b11, 16'h0206);
    rd_chk("R7 lock cleared by reset", 16'h0206);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule